// File: doc/BRIEF.md
# Standby Mode Sequencer

This block steps a small system between normal operation and two low-power modes: a light standby that keeps its configuration and a deep standby that holds only pin state and a few pin flags. Software requests standby with a single strobe and a deep-mode select. The request is taken only once an input reports that every earlier configuration write has landed, so a mode change can never overtake a write that is still in flight. While the block is out of normal operation it gates the core clock and holds the I/O pins. In either standby mode it also switches the oscillator off.

Leaving light standby is triggered by the non-maskable interrupt or by any of sixteen external interrupt lines whose wake enable is set. The oscillator is then restarted, and a settling counter runs for a time chosen by a 5-bit field. When the counter finishes, the block raises a one-cycle wake-exception request to the processor. A wake source that appears in the single cycle in which deep entry is being committed cancels the deep entry and sends the block down the light-standby wake path instead.

Deep standby is left through the non-maskable interrupt or through one of four dedicated wake pins. Each wake pin has its own enable. An enabled pin's activity is recorded only in a sticky status flag, which software clears by writing a one. These flags survive an ordinary reset and are cleared only by a power-on reset. The block also reports an error when a peripheral is in module stop while its interrupt is still pending.

Top module: `standby_ctl`

## Requirements
- R1: While reset is active, and right after it, the state output is 0 (normal run). In this state oscEn is 1, clkGateEn is 0, ioHold is 0 and wakeExc is 0. A power-on reset also clears every deep-pin flag.
- R2: A high sbyReq moves the block out of run state (0) only in a cycle where wrDone is also high. With deepSel at 0 the block enters state 1 and then state 2 (light standby) on the following clock. With deepSel at 1 it enters state 3 and then state 4 (deep standby).
- R3: In every state other than 0, clkGateEn and ioHold are both 1. oscEn is 0 only in states 2 and 4.
- R4: In state 2, a high nmi or a high irqIn[i] with irqWakeEn[i] set moves the block to state 5 (settling) on the next clock.
- R5: An irqIn line whose irqWakeEn bit is clear neither wakes state 2 nor stops the move from state 3 to state 4.
- R6: If a light-standby wake source (R4) is present while the block is in state 3, the block goes to state 5 and not to state 4. A high nmi always has this effect and cannot be masked.
- R7: The block stays in state 5 for exactly 2^(min(N, MAX_STS)+5) cycles, where N is the value of stsSel taken on the clock that enters state 5. The default MAX_STS is 20.
- R8: After a settling interval that began in state 2 or state 3, wakeExc is high for exactly the first cycle back in state 0.
- R9: In state 4 only nmi, or a deep pin with dpinEn and dpinIn both high, starts settling (state 5). irqIn lines have no effect there. The settling that follows returns to state 0 without raising wakeExc.
- R10: dflag[i] is set on the clock after dpinEn[i] and dpinIn[i] are both high, and a one on dflagClr[i] clears it; setting wins over clearing. Deep pins never wake the block from state 2.
- R11: A low rstN alone returns the block to state 0 but leaves dflag unchanged. A low porN clears dflag.
- R12: modStopErr is registered. It is 1 in the cycle after some peripheral has both its modStopped and its modIrqPend bits high, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | System reset, active low, asynchronous |
| porN | input | 1 | Power-on reset, active low, asynchronous; also clears deep-pin flags |
| sbyReq | input | 1 | Standby request strobe |
| deepSel | input | 1 | 1 selects deep standby for the request |
| wrDone | input | 1 | All earlier register writes have completed |
| stsSel | input | 5 | Settling-time select N |
| irqIn | input | NUM_IRQ | External interrupt lines |
| irqWakeEn | input | NUM_IRQ | Per-line standby wake enable |
| nmi | input | 1 | Non-maskable interrupt |
| dpinEn | input | NUM_PIN | Deep-pin input buffer enables |
| dpinIn | input | NUM_PIN | Deep-pin levels |
| dflagClr | input | NUM_PIN | Write-one-to-clear strobes for dflag |
| modStopped | input | NUM_MOD | Peripheral is in module stop |
| modIrqPend | input | NUM_MOD | Peripheral interrupt pending |
| clkGateEn | output | 1 | 1 gates the core clock off |
| oscEn | output | 1 | Oscillator enable |
| ioHold | output | 1 | Hold the I/O pin levels |
| wakeExc | output | 1 | One-cycle wake-exception request |
| dflag | output | NUM_PIN | Sticky deep-pin activity flags |
| modStopErr | output | 1 | Module stop while an interrupt is pending |
| stateOut | output | 3 | Current state code (0 to 5) |

## Verification
The bench builds the block with MAX_STS set to 3, so that saturation already occurs at a 256-cycle interval. This lets it sweep every stsSel value from 0 to 7 and count each settling interval exactly within a short run. The other parameters keep their defaults. The bench sweeps each of the sixteen interrupt lines, first masked and then enabled, every single-bit pairing of the four module-stop and pending inputs, and both abort sources in the deep-entry cycle.

// File: rtl/stby_pkg.sv
package stby_pkg;
  typedef enum logic [2:0] {
    ST_RUN        = 3'd0,
    ST_ENTER_SSBY = 3'd1,
    ST_SSBY       = 3'd2,
    ST_ENTER_DSBY = 3'd3,
    ST_DSBY       = 3'd4,
    ST_SETTLE     = 3'd5
  } stbyState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadSettle;
    logic countEn;
  } dpCtl_t;
endpackage

// File: rtl/stby_datapath.sv
module stby_datapath
  import stby_pkg::*;
#(
  parameter int NUM_IRQ  = 16,
  parameter int NUM_PIN  = 4,
  parameter int NUM_MOD  = 4,
  parameter int STS_W    = 5,
  parameter int MAX_STS  = 20,
  parameter int STS_BIAS = 5
) (
  input  logic               clk,
  input  logic               sysRstN,
  input  logic               porN,
  input  dpCtl_t             ctl,
  input  logic [STS_W-1:0]   stsSel,
  input  logic [NUM_IRQ-1:0] irqIn,
  input  logic [NUM_IRQ-1:0] irqWakeEn,
  input  logic               nmi,
  input  logic [NUM_PIN-1:0] dpinEn,
  input  logic [NUM_PIN-1:0] dpinIn,
  input  logic [NUM_PIN-1:0] dflagClr,
  input  logic [NUM_MOD-1:0] modStopped,
  input  logic [NUM_MOD-1:0] modIrqPend,
  output logic               wakeSby,
  output logic               wakeDeep,
  output logic               settleDone,
  output logic [NUM_PIN-1:0] dflag,
  output logic               modStopErr
);
  localparam int CNT_W = MAX_STS + STS_BIAS + 1;

  logic [CNT_W-1:0] settleCnt;
  logic [CNT_W-1:0] settleLen;
  logic [STS_W-1:0] effN;

  assign wakeSby  = nmi | (|(irqIn & irqWakeEn));
  assign wakeDeep = nmi | (|(dpinEn & dpinIn));

  always_comb begin
    effN      = (stsSel > STS_W'(MAX_STS)) ? STS_W'(MAX_STS) : stsSel;
    settleLen = CNT_W'(1) << (effN + STS_W'(STS_BIAS));
  end

  always_ff @(posedge clk or negedge sysRstN) begin
    if (!sysRstN)                          settleCnt <= '0;
    else if (ctl.loadSettle)               settleCnt <= settleLen - CNT_W'(1);
    else if (ctl.countEn && settleCnt != '0) settleCnt <= settleCnt - CNT_W'(1);
  end

  assign settleDone = (settleCnt == '0);

  // Deep-pin flags: reset only by power-on
  for (genvar i = 0; i < NUM_PIN; i++) begin : g_dflag
    always_ff @(posedge clk or negedge porN) begin
      if (!porN)                        dflag[i] <= 1'b0;
      else if (dpinEn[i] && dpinIn[i])  dflag[i] <= 1'b1;
      else if (dflagClr[i])             dflag[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge sysRstN) begin
    if (!sysRstN) modStopErr <= 1'b0;
    else          modStopErr <= |(modStopped & modIrqPend);
  end
endmodule

// File: rtl/stby_ctrl.sv
module stby_ctrl
  import stby_pkg::*;
(
  input  logic       clk,
  input  logic       sysRstN,
  input  logic       sbyReq,
  input  logic       deepSel,
  input  logic       wrDone,
  input  logic       wakeSby,
  input  logic       wakeDeep,
  input  logic       settleDone,
  output dpCtl_t     ctl,
  output stbyState_e state,
  output logic       wakeExc,
  output logic       clkGateEn,
  output logic       oscEn,
  output logic       ioHold
);
  stbyState_e stateNext;
  logic       fromDeep;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_RUN:        if (sbyReq && wrDone) stateNext = deepSel ? ST_ENTER_DSBY : ST_ENTER_SSBY;
      ST_ENTER_SSBY: stateNext = ST_SSBY;
      ST_SSBY:       if (wakeSby) stateNext = ST_SETTLE;
      ST_ENTER_DSBY: stateNext = wakeSby ? ST_SETTLE : ST_DSBY;
      ST_DSBY:       if (wakeDeep) stateNext = ST_SETTLE;
      ST_SETTLE:     if (settleDone) stateNext = ST_RUN;
      default:       stateNext = ST_RUN;
    endcase
  end

  always_comb begin
    ctl.loadSettle = (stateNext == ST_SETTLE) && (state != ST_SETTLE);
    ctl.countEn    = (state == ST_SETTLE);
  end

  always_ff @(posedge clk or negedge sysRstN) begin
    if (!sysRstN) begin
      state    <= ST_RUN;
      fromDeep <= 1'b0;
      wakeExc  <= 1'b0;
    end else begin
      state   <= stateNext;
      wakeExc <= (state == ST_SETTLE) && settleDone && !fromDeep;
      if (ctl.loadSettle) fromDeep <= (state == ST_DSBY);
    end
  end

  assign clkGateEn = (state != ST_RUN);
  assign ioHold    = (state != ST_RUN);
  assign oscEn     = !((state == ST_SSBY) || (state == ST_DSBY));
endmodule

// File: rtl/standby_ctl.sv
module standby_ctl
  import stby_pkg::*;
#(
  parameter int NUM_IRQ = 16,
  parameter int NUM_PIN = 4,
  parameter int NUM_MOD = 4,
  parameter int MAX_STS = 20
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               porN,
  input  logic               sbyReq,
  input  logic               deepSel,
  input  logic               wrDone,
  input  logic [4:0]         stsSel,
  input  logic [NUM_IRQ-1:0] irqIn,
  input  logic [NUM_IRQ-1:0] irqWakeEn,
  input  logic               nmi,
  input  logic [NUM_PIN-1:0] dpinEn,
  input  logic [NUM_PIN-1:0] dpinIn,
  input  logic [NUM_PIN-1:0] dflagClr,
  input  logic [NUM_MOD-1:0] modStopped,
  input  logic [NUM_MOD-1:0] modIrqPend,
  output logic               clkGateEn,
  output logic               oscEn,
  output logic               ioHold,
  output logic               wakeExc,
  output logic [NUM_PIN-1:0] dflag,
  output logic               modStopErr,
  output logic [2:0]         stateOut
);
  logic       sysRstN;
  dpCtl_t     ctl;
  stbyState_e state;
  logic       wakeSby, wakeDeep, settleDone;

  assign sysRstN  = rstN & porN;
  assign stateOut = state;

  stby_ctrl i_ctrl (
    .clk(clk), .sysRstN(sysRstN), .sbyReq(sbyReq), .deepSel(deepSel),
    .wrDone(wrDone), .wakeSby(wakeSby), .wakeDeep(wakeDeep),
    .settleDone(settleDone), .ctl(ctl), .state(state), .wakeExc(wakeExc),
    .clkGateEn(clkGateEn), .oscEn(oscEn), .ioHold(ioHold)
  );

  stby_datapath #(
    .NUM_IRQ(NUM_IRQ), .NUM_PIN(NUM_PIN), .NUM_MOD(NUM_MOD),
    .STS_W(5), .MAX_STS(MAX_STS), .STS_BIAS(5)
  ) i_dp (
    .clk(clk), .sysRstN(sysRstN), .porN(porN), .ctl(ctl), .stsSel(stsSel),
    .irqIn(irqIn), .irqWakeEn(irqWakeEn), .nmi(nmi), .dpinEn(dpinEn),
    .dpinIn(dpinIn), .dflagClr(dflagClr), .modStopped(modStopped),
    .modIrqPend(modIrqPend), .wakeSby(wakeSby), .wakeDeep(wakeDeep),
    .settleDone(settleDone), .dflag(dflag), .modStopErr(modStopErr)
  );
endmodule

// File: rtl/standby_ctl_chk.sv
module standby_ctl_chk #(
  parameter int NUM_IRQ = 16,
  parameter int NUM_PIN = 4
) (
  input logic               clk,
  input logic               rstN,
  input logic               porN,
  input logic               sbyReq,
  input logic               wrDone,
  input logic               nmi,
  input logic [NUM_IRQ-1:0] irqIn,
  input logic [NUM_IRQ-1:0] irqWakeEn,
  input logic [NUM_PIN-1:0] dpinEn,
  input logic [NUM_PIN-1:0] dpinIn,
  input logic [NUM_PIN-1:0] dflag,
  input logic               wakeExc,
  input logic [2:0]         stateOut
);
  p_write_gate_r2: assert property (@(posedge clk) disable iff (!rstN || !porN)
    (stateOut == 3'd0 && sbyReq && !wrDone) |=> stateOut == 3'd0);

  p_masked_line_r5: assert property (@(posedge clk) disable iff (!rstN || !porN)
    (stateOut == 3'd2 && !nmi && (irqIn & irqWakeEn) == '0) |=> stateOut == 3'd2);

  p_nmi_abort_r6: assert property (@(posedge clk) disable iff (!rstN || !porN)
    (stateOut == 3'd3 && nmi) |=> stateOut == 3'd5);

  p_exc_after_settle_r8: assert property (@(posedge clk) disable iff (!rstN || !porN)
    wakeExc |-> ($past(stateOut) == 3'd5 && stateOut == 3'd0));

  p_flag_set_r10: assert property (@(posedge clk) disable iff (!rstN || !porN)
    ((dpinEn & dpinIn) != '0) |=> ((dflag & $past(dpinEn & dpinIn)) == $past(dpinEn & dpinIn)));
endmodule

bind standby_ctl standby_ctl_chk #(.NUM_IRQ(NUM_IRQ), .NUM_PIN(NUM_PIN)) i_chk (
  .clk(clk), .rstN(rstN), .porN(porN), .sbyReq(sbyReq), .wrDone(wrDone),
  .nmi(nmi), .irqIn(irqIn), .irqWakeEn(irqWakeEn), .dpinEn(dpinEn),
  .dpinIn(dpinIn), .dflag(dflag), .wakeExc(wakeExc), .stateOut(stateOut)
);

// File: tb/test_standby_ctl.sv
module test_standby_ctl;
  localparam int CLK_PERIOD = 10;
  localparam int MAXN = 3;

  logic clk = 1'b0;
  logic rstN, porN, sbyReq, deepSel, wrDone, nmi;
  logic [4:0]  stsSel;
  logic [15:0] irqIn, irqWakeEn;
  logic [3:0]  dpinEn, dpinIn, dflagClr, modStopped, modIrqPend, dflag;
  logic clkGateEn, oscEn, ioHold, wakeExc, modStopErr;
  logic [2:0] stateOut;
  int tests = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  standby_ctl #(.MAX_STS(MAXN)) i_standby_ctl (
    .clk(clk), .rstN(rstN), .porN(porN), .sbyReq(sbyReq), .deepSel(deepSel),
    .wrDone(wrDone), .stsSel(stsSel), .irqIn(irqIn), .irqWakeEn(irqWakeEn),
    .nmi(nmi), .dpinEn(dpinEn), .dpinIn(dpinIn), .dflagClr(dflagClr),
    .modStopped(modStopped), .modIrqPend(modIrqPend), .clkGateEn(clkGateEn),
    .oscEn(oscEn), .ioHold(ioHold), .wakeExc(wakeExc), .dflag(dflag),
    .modStopErr(modStopErr), .stateOut(stateOut)
  );

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic enterStby(input logic deep);
    @(negedge clk); sbyReq = 1'b1; deepSel = deep; wrDone = 1'b1;
    @(negedge clk); sbyReq = 1'b0;
    chk("R2 entry state", stateOut, deep ? 3 : 1);
    chk("R3 osc on during entry", oscEn, 1);
    @(negedge clk);
    chk("R2 standby state", stateOut, deep ? 4 : 2);
    chk("R3 osc off", oscEn, 0);
    chk("R3 hold", {ioHold, clkGateEn}, 3);
  endtask

  // Called at a negedge where the block has just entered state 5
  task automatic measureSettle(input int expLen, input int expExc, input string req);
    int cnt = 0;
    while (stateOut == 3'd5 && cnt < 100000) begin cnt++; @(negedge clk); end
    chk({req, " R7 settle length"}, cnt, expLen);
    chk({req, " state back to run"}, stateOut, 0);
    chk({req, " R8 wakeExc first run cycle"}, wakeExc, expExc);
    @(negedge clk);
    chk({req, " R8 wakeExc one cycle"}, wakeExc, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rstN = 0; porN = 0; sbyReq = 0; deepSel = 0; wrDone = 0; nmi = 0;
    stsSel = 0; irqIn = 0; irqWakeEn = 0; dpinEn = 0; dpinIn = 0;
    dflagClr = 0; modStopped = 0; modIrqPend = 0;
    repeat (3) @(negedge clk);
    // R1
    chk("R1 reset state", stateOut, 0);
    chk("R1 reset outputs", {oscEn, clkGateEn, ioHold, wakeExc}, 8);
    chk("R1 reset dflag", dflag, 0);
    rstN = 1; porN = 1;
    @(negedge clk);
    chk("R1 run after reset", stateOut, 0);

    // R2: held off without wrDone
    sbyReq = 1; wrDone = 0;
    repeat (3) @(negedge clk);
    chk("R2 held off without wrDone", stateOut, 0);
    sbyReq = 0;

    // R5 / R10: masked lines and deep pins do not wake light standby
    enterStby(1'b0);
    for (int i = 0; i < 16; i++) begin
      irqWakeEn = ~(16'(1) << i); irqIn = 16'(1) << i;
      @(negedge clk); @(negedge clk);
      chk($sformatf("R5 masked line %0d", i), stateOut, 2);
    end
    irqIn = 0;
    dpinEn = 4'hF; dpinIn = 4'hF;
    @(negedge clk); @(negedge clk);
    chk("R10 deep pin no wake in light standby", stateOut, 2);
    chk("R10 all flags set", dflag, 15);
    dpinIn = 0; dpinEn = 0; dflagClr = 4'b0101;
    @(negedge clk); dflagClr = 0;
    chk("R10 w1c partial", dflag, 4'b1010);
    dflagClr = 4'hF; dpinEn = 4'b0010; dpinIn = 4'b0010;
    @(negedge clk); dflagClr = 0; dpinEn = 0; dpinIn = 0;
    chk("R10 set wins over clear", dflag, 4'b0010);
    dflagClr = 4'hF; @(negedge clk); dflagClr = 0;
    chk("R10 cleared", dflag, 0);

    // R4: each enabled line wakes; settle N=0
    stsSel = 0;
    for (int i = 0; i < 16; i++) begin
      irqWakeEn = 16'(1) << i; irqIn = 16'(1) << i;
      @(negedge clk); irqIn = 0;
      chk($sformatf("R4 line %0d wakes", i), stateOut, 5);
      measureSettle(32, 1, "R4");
      enterStby(1'b0);
    end
    irqWakeEn = 0;
    nmi = 1; @(negedge clk); nmi = 0;
    chk("R4 nmi wakes", stateOut, 5);
    measureSettle(32, 1, "R4 nmi");

    // R7: sweep settling field including saturation
    for (int n = 0; n < 8; n++) begin
      enterStby(1'b0);
      stsSel = 5'(n); irqWakeEn = 16'h8000; irqIn = 16'h8000;
      @(negedge clk); irqIn = 0; stsSel = 5'(7 - n);
      chk($sformatf("R7 N=%0d settling", n), stateOut, 5);
      measureSettle(1 << (((n > MAXN) ? MAXN : n) + 5), 1, "R7");
    end
    stsSel = 0;

    // R6: conflicts in deep entry
    irqWakeEn = 16'h0010;
    @(negedge clk); sbyReq = 1; deepSel = 1;
    @(negedge clk); sbyReq = 0; irqIn = 16'h0010;
    chk("R6 in deep entry", stateOut, 3);
    @(negedge clk); irqIn = 0;
    chk("R6 enabled line aborts deep entry", stateOut, 5);
    measureSettle(32, 1, "R6 irq");
    irqWakeEn = 0;
    @(negedge clk); sbyReq = 1; deepSel = 1;
    @(negedge clk); sbyReq = 0; nmi = 1;
    @(negedge clk); nmi = 0;
    chk("R6 nmi aborts deep entry", stateOut, 5);
    measureSettle(32, 1, "R6 nmi");
    @(negedge clk); sbyReq = 1; deepSel = 1;
    @(negedge clk); sbyReq = 0; irqIn = 16'hFFFF;
    @(negedge clk);
    chk("R5 masked line no abort", stateOut, 4);

    // R9: deep standby wake sources
    irqWakeEn = 16'hFFFF;
    @(negedge clk); @(negedge clk);
    chk("R9 irq ignored in deep", stateOut, 4);
    irqIn = 0; irqWakeEn = 0; dpinIn = 4'b0100;
    @(negedge clk); @(negedge clk);
    chk("R9 disabled pin ignored", stateOut, 4);
    dpinEn = 4'b0100;
    @(negedge clk); dpinEn = 0; dpinIn = 0;
    chk("R9 enabled pin wakes deep", stateOut, 5);
    measureSettle(32, 0, "R9 pin");
    chk("R10 pin flag recorded", dflag, 4'b0100);
    enterStby(1'b1);
    nmi = 1; @(negedge clk); nmi = 0;
    chk("R9 nmi wakes deep", stateOut, 5);
    measureSettle(32, 0, "R9 nmi");

    // R11: reset kinds
    enterStby(1'b0);
    rstN = 0; @(negedge clk);
    chk("R11 rstN keeps dflag", dflag, 4'b0100);
    chk("R11 rstN to run", stateOut, 0);
    rstN = 1; @(negedge clk);
    porN = 0; @(negedge clk);
    chk("R11 porN clears dflag", dflag, 0);
    porN = 1; @(negedge clk);

    // R12: module stop with pending interrupt
    for (int i = 0; i < 4; i++) begin
      for (int j = 0; j < 4; j++) begin
        modStopped = 4'(1 << i); modIrqPend = 4'(1 << j);
        @(negedge clk);
        chk($sformatf("R12 stop %0d pend %0d", i, j), modStopErr, (i == j) ? 1 : 0);
      end
    end
    modStopped = 0; modIrqPend = 0;
    @(negedge clk);
    chk("R12 clears", modStopErr, 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule